// File: doc/BRIEF.md
# Constant Times-Six Shift-Add Multiplier

This block multiplies a 4-bit unsigned operand by the fixed value six and returns a 7-bit unsigned product. Six is binary 110, so only two shifted copies of the operand contribute: the operand moved up one place and the operand moved up two places. No AND gating is used to form partial products. The block wires these two copies into a short ripple chain of explicit half-adder and full-adder cells.

The lowest product bit is always zero, and the next bit is a straight wire from operand bit 0. The remaining five bits come out of a four-stage chain. From the bottom up, the chain is a half-adder, two full-adders and a closing half-adder whose carry becomes the top product bit. The unit has no clock, so it can be placed wherever a scaled-by-six index or address is needed inside a single cycle. Its operand and product are plain data pins with no handshake, because there is nothing to hold or throttle.

Top module: `mul6_shiftadd`

## Requirements
- R1: For every operand value 0 to 15, `product` equals the operand times six as an unsigned 7-bit number. The largest result is 90, at operand 15. The output follows the input combinationally, with no clock or storage.
- R2: Product bit 0 is 0 for every operand.
- R3: Product bit 1 equals operand bit 0.
- R4: Product bit 2 is the sum output of a half-adder fed by operand bits 1 and 0, that is their XOR.
- R5: Product bit 3 is the full-adder sum of operand bits 2 and 1 and the carry from the bit-2 stage. Product bit 4 is the full-adder sum of operand bits 3 and 2 and the carry from the bit-3 stage.
- R6: Product bit 5 is the half-adder sum of operand bit 3 and the carry out of the bit-4 stage. Product bit 6 is that half-adder's carry, so it is 1 exactly for operands 11 to 15.
- R7: Each adder cell's carry and sum, read as a 2-bit number, equal the arithmetic sum of its inputs. The chain holds exactly two half-adder cells and two full-adder cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | 4 | Unsigned value to be scaled by six |
| product | output | 7 | Unsigned result, operand times six |

## Verification
The assertions sit inside the RTL and are checked whenever their inputs change. Inside each adder cell, they check that carry and sum together equal the arithmetic sum of the cell's inputs (R7). At the top level, they check that the whole product equals six times the operand and never exceeds 90 (R1). What the assertions cannot show is how each output bit is wired to particular operand bits and carries (R2 to R6). The bench shows that by sweeping all sixteen operands and comparing each bit field against values it computes from the requirement text.

// File: rtl/mul6_pkg.sv
package mul6_pkg;
  parameter int unsigned OP_W   = 4;
  parameter int unsigned PROD_W = OP_W + 3;
  parameter int unsigned FACTOR = 6;
  localparam int unsigned MAX_PRODUCT = ((1 << OP_W) - 1) * FACTOR;
endpackage

// File: rtl/mul6_half_add.sv
module mul6_half_add (
  input  logic in_a,
  input  logic in_b,
  output logic sum,
  output logic carry
);
  assign sum   = in_a ^ in_b;
  assign carry = in_a & in_b;

  always_comb begin
    if (!$isunknown({in_a, in_b})) begin
      assert_ha_arith_R7: assert ({carry, sum} == (2'(in_a) + 2'(in_b)))
        else $error("half-adder arithmetic mismatch");
    end
  end
endmodule

// File: rtl/mul6_full_add.sv
module mul6_full_add (
  input  logic in_a,
  input  logic in_b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic axb;
  assign axb  = in_a ^ in_b;
  assign sum  = axb ^ cin;
  assign cout = (in_a & in_b) | (axb & cin);

  always_comb begin
    if (!$isunknown({in_a, in_b, cin})) begin
      assert_fa_arith_R7: assert ({cout, sum} == (2'(in_a) + 2'(in_b) + 2'(cin)))
        else $error("full-adder arithmetic mismatch");
    end
  end
endmodule

// File: rtl/mul6_shiftadd.sv
module mul6_shiftadd
  import mul6_pkg::*;
(
  input  logic [OP_W-1:0]   operand,
  output logic [PROD_W-1:0] product
);
  // Chain stage k (0 .. OP_W-1) produces product bit k+2.
  localparam int unsigned STAGES = OP_W;
  logic [STAGES-1:0] stage_sum;
  logic [STAGES-1:0] stage_carry;

  // Lowest stage (R4): operand bits 1 and 0 in a half-adder.
  mul6_half_add u_ha_low (
    .in_a  (operand[1]),
    .in_b  (operand[0]),
    .sum   (stage_sum[0]),
    .carry (stage_carry[0])
  );

  // Middle stages (R5): operand bits k+1 and k plus the carry from below.
  for (genvar k = 1; k <= int'(STAGES) - 2; k++) begin : g_mid
    mul6_full_add u_fa (
      .in_a (operand[k+1]),
      .in_b (operand[k]),
      .cin  (stage_carry[k-1]),
      .sum  (stage_sum[k]),
      .cout (stage_carry[k])
    );
  end

  // Top stage (R6): the highest operand bit plus the incoming carry.
  mul6_half_add u_ha_top (
    .in_a  (operand[OP_W-1]),
    .in_b  (stage_carry[STAGES-2]),
    .sum   (stage_sum[STAGES-1]),
    .carry (stage_carry[STAGES-1])
  );

  // R2 and R3: bit 0 is tied low and bit 1 is a wire from operand bit 0.
  assign product = {stage_carry[STAGES-1], stage_sum, operand[0], 1'b0};

  always_comb begin
    if (!$isunknown(operand)) begin
      assert_times_six_R1: assert (32'(product) == 32'(operand) * FACTOR)
        else $error("product is not six times operand");
      assert_in_range_R1: assert (32'(product) <= MAX_PRODUCT)
        else $error("product above the largest legal value");
    end
  end
endmodule

// File: tb/mul6_shiftadd_tb.sv
module mul6_shiftadd_tb;
  logic       clk = 1'b0;
  logic [3:0] operand = 4'd0;
  logic [6:0] product;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  logic [10:0] sb_q[$];   // {operand, expected product}

  always #2.5 clk = ~clk;   // 200 MHz

  mul6_shiftadd u_dut (.operand(operand), .product(product));

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (operand=%0d)", req, act, exp_v, operand);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    @(posedge clk);
    operand <= v;
    sb_q.push_back({v, 7'(int'(v) * 6)});
  endtask

  // Monitor: compares on the falling edge, after the new operand has settled.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      logic [10:0] item;
      logic [3:0]  a;
      logic [6:0]  e;
      int          c2, c3, c4, s3, s4, s5, c5;
      item = sb_q.pop_front();
      a = item[10:7];
      e = item[6:0];
      chk("R1 product", int'(product), int'(e));
      chk("R2 bit0", int'(product[0]), 0);
      chk("R3 bit1", int'(product[1]), int'(a[0]));
      chk("R4 bit2", int'(product[2]), int'(a[1] ^ a[0]));
      c2 = int'(a[1] & a[0]);
      s3 = (int'(a[2]) + int'(a[1]) + c2) % 2;
      c3 = (int'(a[2]) + int'(a[1]) + c2) / 2;
      s4 = (int'(a[3]) + int'(a[2]) + c3) % 2;
      c4 = (int'(a[3]) + int'(a[2]) + c3) / 2;
      chk("R5 bits4:3", int'(product[4:3]), s4 * 2 + s3);
      s5 = (int'(a[3]) + c4) % 2;
      c5 = (int'(a[3]) + c4) / 2;
      chk("R6 bits6:5", int'(product[6:5]), c5 * 2 + s5);
      chk("R6 bit6 range", int'(product[6]), (a >= 4'd11) ? 1 : 0);
      chk("R7 cell sums", int'(product[6:2]), int'(a) + int'(a >> 1));
    end
  end

  initial begin
    #1;
    chk("R1 idle zero", int'(product), 0);
    // Ascending sweep, then a descending one so every input bit flips both ways.
    for (int i = 0; i < 16; i++) drive(4'(i));
    for (int i = 15; i >= 0; i--) drive(4'(i));
    drive(4'd15); drive(4'd0); drive(4'd10); drive(4'd11); drive(4'd5);
    @(posedge clk);
    @(posedge clk);
    chk("R1 queue drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule